// File: doc/BRIEF.md
# Write-Only I2C Command Register Target

This block is an I2C target that accepts only write transfers and owns a small bank of 8-bit command registers. A master writes a register with a three-byte transfer: the target's address byte with the direction bit cleared, a pointer byte that picks one register, and a value byte. Each accepted byte is acknowledged by pulling SDA low through the ninth clock. The block samples SCL and SDA with the system clock. It detects START, repeated START and STOP, shifts bytes in MSB first, and drives an open-drain pull-down enable for the acknowledge.

Writes are double-buffered. An accepted value byte goes into a staging latch for the selected register, and the visible registers do not change at that point. Staged values are copied into the visible registers only on a STOP that qualifies. Staged data survives any number of repeated STARTs, including STARTs aimed at other targets on the bus, so one global STOP can update several devices together. A STOP that falls inside an incomplete frame is ignored. Once the pointer byte of a frame has been accepted, the block stays locked against commits until a whole new value byte has been accepted. Only the last complete data is ever committed. Each commit raises a one-cycle update strobe.

Top module: `i2cw_cmd_target`

## Requirements
- R1: After reset all command registers read zero, the update strobe is low and the SDA pull-down enable is off.
- R2: Bytes are received MSB first, eight data clocks then a ninth acknowledge clock. To acknowledge, the block turns the pull-down on after SCL falls at the end of the eighth bit and keeps SDA low through the whole high phase of the ninth clock. It releases SDA after that clock falls. A byte sent in reversed bit order (0x48 instead of 0x12) is therefore not acknowledged.
- R3: Only the address byte 0x12 (7-bit address 0001001, direction bit 0 in the LSB) is acknowledged. Any other address byte, including 0x13 (read), is not acknowledged, and no later byte of that frame is acknowledged.
- R4: The pointer byte is acknowledged when it is 0x00 to 0x03. Any larger value is not acknowledged, and the frame is abandoned (its value byte gets no acknowledge and is not staged).
- R5: The value byte that follows an accepted pointer is acknowledged. Any further byte in the same frame is not acknowledged and has no effect.
- R6: An accepted value byte is staged for the register named by the pointer. The command register outputs do not change before a qualifying STOP.
- R7: A STOP that arrives while data is staged and the block is not locked copies all staged values into the command registers. The update strobe is high for exactly one clock, in the same cycle the new values first appear. Register i sits at output bits [8i+7:8i].
- R8: Staged data survives repeated STARTs, including frames addressed to other targets, until a qualifying STOP commits it.
- R9: Once a pointer byte is accepted, STOPs are ignored, even with older data staged, until a value byte is accepted. This lock persists across further STOPs and STARTs.
- R10: A STOP with no staged data (for example, after address and pointer only) causes no update and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | Pull-down enable for SDA; 1 drives the line low |
| cmd_regs_o | output | NUM_REGS*DW (32) | Committed command registers, register i at bits [8i+7:8i] |
| upd_o | output | 1 | One-cycle strobe on every commit |

## Verification
The hardest situation to reach is a locked frame on top of older staged data. In that case a STOP must be refused although something is pending. The refusal must also hold across a later STOP and a frame to a foreign address. The stimulus stages one register and issues a repeated START with address and pointer but no value byte. It then issues a STOP, a START to another target and a second STOP, checking after each that no strobe occurs. Finally it sends a complete frame and expects one commit that carries both the old and the new value. A scoreboard queue holds every expected register snapshot, and a monitor matches each strobe against the queue. Any strobe that arrives while the queue is empty counts as a failure.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ADDR,
    FR_SUB,
    FR_DATA,
    FR_SKIP
  } frame_st_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{{WIDTH{RST_VAL}}}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA edges only count as conditions while SCL stays high across both samples
  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx #(
  parameter  int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic          ack_ok,
  output logic [DW-1:0] rx_byte,
  output logic          byte_done,
  output logic          sda_oe,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  logic          aph_q, aph_d;

  always_comb begin
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    ack_d     = ack_q;
    aph_d     = aph_q;
    byte_done = 1'b0;
    if (start_det || stop_det) begin
      cnt_d = '0;
      ack_d = 1'b0;
      aph_d = 1'b0;
    end else if (scl_rise && (cnt_q < FULL)) begin
      sh_d  = {sh_q[DW-2:0], sda_s};
      cnt_d = cnt_q + 1'b1;
    end else if (scl_fall && (cnt_q == FULL)) begin
      if (!aph_q) begin
        byte_done = 1'b1;
        aph_d     = 1'b1;
        ack_d     = ack_ok;
      end else begin
        aph_d = 1'b0;
        ack_d = 1'b0;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ack_q <= 1'b0;
      aph_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
      aph_q <= aph_d;
    end
  end

  assign rx_byte = sh_q;
  assign sda_oe  = ack_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/i2cw_frame_ctrl.sv
module i2cw_frame_ctrl
  import i2cw_pkg::*;
#(
  parameter  int DW       = 8,
  parameter  int NUM_REGS = 4,
  parameter  int DEV_ADDR = 9,
  localparam int PW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   byte_done,
  input  logic [DW-1:0]          rx_byte,
  output logic                   ack_ok,
  output logic [NUM_REGS*DW-1:0] cmd_regs,
  output logic                   upd,
  output logic                   lock_q,
  output logic                   pend_q
);
  localparam logic [DW-1:0] ADDR_WR = DW'(DEV_ADDR << 1);
  localparam logic [DW-1:0] SUB_LIM = DW'(NUM_REGS);

  frame_st_e     st_q, st_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          lock_d, pend_d;
  logic          hold_we, commit, upd_q;

  always_comb begin
    unique case (st_q)
      FR_ADDR: ack_ok = (rx_byte == ADDR_WR);
      FR_SUB:  ack_ok = (rx_byte < SUB_LIM);
      FR_DATA: ack_ok = 1'b1;
      default: ack_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    lock_d  = lock_q;
    pend_d  = pend_q;
    hold_we = 1'b0;
    commit  = 1'b0;
    if (start_det) begin
      st_d = FR_ADDR;
    end else if (stop_det) begin
      st_d = FR_IDLE;
      if (pend_q && !lock_q) begin
        commit = 1'b1;
        pend_d = 1'b0;
      end
    end else if (byte_done) begin
      unique case (st_q)
        FR_ADDR: st_d = ack_ok ? FR_SUB : FR_SKIP;
        FR_SUB: begin
          if (ack_ok) begin
            st_d   = FR_DATA;
            ptr_d  = rx_byte[PW-1:0];
            lock_d = 1'b1;
          end else begin
            st_d = FR_SKIP;
          end
        end
        FR_DATA: begin
          hold_we = 1'b1;
          pend_d  = 1'b1;
          lock_d  = 1'b0;
          st_d    = FR_SKIP;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      ptr_q  <= '0;
      lock_q <= 1'b0;
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      lock_q <= lock_d;
      pend_q <= pend_d;
      upd_q  <= commit;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] hold_q, cmd_q;
    logic          hold_en;
    assign hold_en = hold_we && (ptr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        cmd_q  <= '0;
      end else begin
        if (hold_en) hold_q <= rx_byte;
        if (commit)  cmd_q  <= hold_q;
      end
    end
    assign cmd_regs[g*DW +: DW] = cmd_q;
  end

  assign upd = upd_q;
endmodule

// File: rtl/i2cw_cmd_target.sv
module i2cw_cmd_target #(
  parameter  int DW          = 8,
  parameter  int NUM_REGS    = 4,
  parameter  int DEV_ADDR    = 9,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(DW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NUM_REGS*DW-1:0] cmd_regs_o,
  output logic                   upd_o
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] rx_byte;
  logic          byte_done, ack_ok;
  logic [CW-1:0] bit_cnt;
  logic          lock_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  i2cw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  ({scl_s, sda_s})
  );

  i2cw_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cw_byte_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_s    (sda_s),
    .ack_ok   (ack_ok),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .sda_oe   (sda_oe_o),
    .bit_cnt  (bit_cnt)
  );

  i2cw_frame_ctrl #(.DW(DW), .NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .ack_ok   (ack_ok),
    .cmd_regs (cmd_regs_o),
    .upd      (upd_o),
    .lock_q   (lock_q),
    .pend_q   (pend_q)
  );
endmodule

// File: rtl/i2cw_cmd_checker.sv
module i2cw_cmd_checker #(
  parameter  int DW       = 8,
  parameter  int NUM_REGS = 4,
  localparam int CW       = $clog2(DW + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   sda_oe_o,
  input logic [NUM_REGS*DW-1:0] cmd_regs_o,
  input logic                   upd_o,
  input logic                   lock_q,
  input logic                   pend_q,
  input logic [CW-1:0]          bit_cnt
);
  // R2: the pull-down is only on during the acknowledge clock
  a_r2_ack_ninth_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (bit_cnt == CW'(DW)));

  // R2: the pull-down only toggles while SCL is low
  a_r2_ack_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  // R6: visible registers move only together with the strobe
  a_r6_regs_move_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_regs_o) |-> upd_o);

  // R7: strobe lasts one clock
  a_r7_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R9: no commit while a frame holds the lock
  a_r9_locked_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> !$past(lock_q));

  // R10: a commit needs staged data
  a_r10_commit_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(pend_q));
endmodule

bind i2cw_cmd_target i2cw_cmd_checker #(.DW(DW), .NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_s     (scl_s),
  .sda_oe_o  (sda_oe_o),
  .cmd_regs_o(cmd_regs_o),
  .upd_o     (upd_o),
  .lock_q    (lock_q),
  .pend_q    (pend_q),
  .bit_cnt   (bit_cnt)
);

// File: tb/sim_i2cw_cmd_target.sv
`timescale 1ns/1ps
module sim_i2cw_cmd_target;
  localparam int DW = 8;
  localparam int NR = 4;
  localparam int RW = DW * NR;
  localparam int Q_NS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe_o, upd_o;
  logic [RW-1:0] cmd_regs_o;

  int checks = 0;
  int fails = 0;
  int upd_cnt = 0;
  logic [RW-1:0] exp_q[$];
  logic [DW-1:0] model [NR];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe_o;

  i2cw_cmd_target u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe_o),
    .cmd_regs_o(cmd_regs_o),
    .upd_o     (upd_o)
  );

  task automatic chk(input logic ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] snap();
    logic [RW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  // scoreboard monitor: every strobe must match the next expected snapshot
  initial begin
    logic [RW-1:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && upd_o) begin
        upd_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected update", cmd_regs_o, '0);
        end else begin
          e = exp_q.pop_front();
          chk(cmd_regs_o === e, "R7 committed registers", cmd_regs_o, e);
        end
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #(Q_NS);
    scl_m = 1'b1; #(Q_NS);
    sda_m = 1'b0; #(Q_NS);
    scl_m = 1'b0; #(Q_NS);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(Q_NS);
    scl_m = 1'b1; #(Q_NS);
    sda_m = 1'b1; #(4 * Q_NS);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a0, a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #(Q_NS);
      scl_m = 1'b1; #(2 * Q_NS);
      scl_m = 1'b0; #(Q_NS);
    end
    sda_m = 1'b1; #(Q_NS);
    scl_m = 1'b1; #(2);
    a0 = ~sda_line; #(Q_NS);
    a1 = ~sda_line; #(Q_NS - 4);
    a2 = ~sda_line; #(2);
    scl_m = 1'b0; #(Q_NS);
    chk(((a0 & a1 & a2) == exp_ack) && ((a0 | a1 | a2) == exp_ack), req,
        RW'({a0, a1, a2}), RW'({3{exp_ack}}));
  endtask

  task automatic frame(input logic [7:0] sub, input logic [7:0] val);
    bus_start();
    wr_byte(8'h12, 1'b1, "R3 address ack");
    wr_byte(sub, 1'b1, "R4 pointer ack");
    wr_byte(val, 1'b1, "R5 value ack");
    model[sub[1:0]] = val;
  endtask

  task automatic no_upd_since(input int base, input string req);
    repeat (20) @(negedge clk);
    chk(upd_cnt == base, req, RW'(upd_cnt), RW'(base));
  endtask

  initial begin
    int base;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(cmd_regs_o == '0, "R1 registers zero", cmd_regs_o, '0);
    chk(!upd_o && !sda_oe_o, "R1 strobe and pull-down off", RW'({upd_o, sda_oe_o}), '0);

    // R7 basic write and commit
    frame(8'h01, 8'hA5);
    exp_q.push_back(snap());
    bus_stop();
    chk(upd_cnt == 1, "R7 one commit", RW'(upd_cnt), RW'(1));

    // R3 wrong address, read bit; R2 reversed bit order
    base = upd_cnt;
    bus_start();
    wr_byte(8'h14, 1'b0, "R3 foreign address nack");
    wr_byte(8'h02, 1'b0, "R3 later byte nack");
    bus_start();
    wr_byte(8'h13, 1'b0, "R3 read bit nack");
    bus_start();
    wr_byte(8'h48, 1'b0, "R2 reversed order nack");
    bus_stop();
    no_upd_since(base, "R3 no update after rejected frames");

    // R4 pointer out of range
    bus_start();
    wr_byte(8'h12, 1'b1, "R4 address ack");
    wr_byte(8'h04, 1'b0, "R4 pointer 0x04 nack");
    wr_byte(8'h77, 1'b0, "R4 value after bad pointer nack");
    bus_stop();
    no_upd_since(base, "R4 abandoned frame no update");
    chk(cmd_regs_o == snap(), "R4 registers unchanged", cmd_regs_o, snap());

    // R5 extra byte, R6 hold before STOP, R8 survives repeated START to other device
    frame(8'h00, 8'h11);
    wr_byte(8'h99, 1'b0, "R5 fourth byte nack");
    repeat (10) @(negedge clk);
    chk(cmd_regs_o[7:0] == 8'h00, "R6 register not yet updated", cmd_regs_o, {24'h0, 8'h00} | (cmd_regs_o & ~RW'(8'hFF)));
    bus_start();
    wr_byte(8'hA0, 1'b0, "R8 other device nack");
    wr_byte(8'h00, 1'b0, "R8 other device byte nack");
    no_upd_since(base, "R8 no commit on repeated START");
    exp_q.push_back(snap());
    bus_stop();
    chk(upd_cnt == base + 1, "R8 commit after repeated START", RW'(upd_cnt), RW'(base + 1));

    // R8 two frames, one STOP
    base = upd_cnt;
    frame(8'h02, 8'h22);
    frame(8'h03, 8'h33);
    exp_q.push_back(snap());
    bus_stop();
    chk(upd_cnt == base + 1, "R8 single commit for two frames", RW'(upd_cnt), RW'(base + 1));

    // R10 address and pointer only, nothing staged
    base = upd_cnt;
    bus_start();
    wr_byte(8'h12, 1'b1, "R10 address ack");
    wr_byte(8'h00, 1'b1, "R10 pointer ack");
    bus_stop();
    no_upd_since(base, "R10 STOP without staged data");
    frame(8'h00, 8'h44);
    exp_q.push_back(snap());
    bus_stop();
    chk(upd_cnt == base + 1, "R10 full frame then commits", RW'(upd_cnt), RW'(base + 1));

    // R9 lock with older staged data
    base = upd_cnt;
    frame(8'h01, 8'h55);
    bus_start();
    wr_byte(8'h12, 1'b1, "R9 address ack");
    wr_byte(8'h02, 1'b1, "R9 pointer ack");
    bus_stop();
    no_upd_since(base, "R9 STOP ignored while locked");
    bus_start();
    wr_byte(8'h50, 1'b0, "R9 other device nack");
    bus_stop();
    no_upd_since(base, "R9 lock persists across STOP");
    chk(cmd_regs_o[15:8] == 8'hA5, "R9 register 1 still old", RW'(cmd_regs_o[15:8]), RW'(8'hA5));
    frame(8'h02, 8'h66);
    exp_q.push_back(snap());
    bus_stop();
    chk(upd_cnt == base + 1, "R9 commit after full frame", RW'(upd_cnt), RW'(base + 1));

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected commits seen", RW'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule